// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the register-side half of a single-channel SPI master. A host reaches it through a simple read/write register port. The block keeps the enable, clock, word-size and frame settings, and drives them out to a separate serial shifting engine. It owns an 8-deep, 32-bit transmit queue and an 8-deep, 32-bit receive queue. The engine drains the transmit queue and fills the receive queue through a one-word valid/ready handshake.

Both queues sit behind one data address. Writing that address loads a word to send, and reading it takes the oldest received word. Interrupt flags for overrun, receive threshold and transmit drain are read at one address and cleared by writing ones to that same address. A single registered interrupt line combines the flags that are enabled. The receive-threshold flag lets software sleep until a whole batch of words has returned.

Top module: `spi_front`

## Requirements
- R1: After synchronous reset every register reads 0, `irq` is 0, `tx_valid` is 0 and `bus_rdata` is 0.
- R2: The following registers read back what was written. Offsets 0x04, 0x08, 0x0C and 0x10 keep all 32 bits. Offset 0x00 keeps only bit 0 (enable). Offset 0x18 keeps only bits 4, 3 and 0. Offset 0x20 keeps only bits 11:8 (TX threshold) and 3:0 (RX threshold), and its flush bits read as 0. All other bits read 0. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: A write to 0x24 appends to the transmit queue, which holds 8 words. A write made while the queue is full is dropped. Words leave in the order they were written.
- R4: `tx_valid` is high only while enable (0x00 bit 0) is 1 and the transmit queue holds a word. A word leaves the queue on a cycle with `tx_valid` and `tx_ready` both high. Clearing enable lowers `tx_valid`.
- R5: A word offered with `rx_valid` is appended to the receive queue. A read of 0x24 returns and removes the oldest word, and returns 0 when the queue is empty. Bit 0 of 0x14 is 1 while the receive queue is not empty.
- R6: A word offered while the receive queue already holds 8 words is discarded and sets the overrun flag (0x1C bit 0). The flag stays set until it is cleared.
- R7: When the receive count becomes equal to a nonzero RX threshold, the receive-complete flag (0x1C bit 3) is set. Bit 9 of 0x1C reads 1 exactly while the count equals that nonzero threshold.
- R8: A transmit pop that leaves the transmit queue empty sets the transmit-complete flag (0x1C bit 4).
- R9: Writing 0x1C clears each of the flags at bits 4, 3 and 0 whose written bit is 1. Flags whose written bit is 0 are left unchanged.
- R10: Writing 1 to 0x20 bit 12 empties the transmit queue. Writing 1 to 0x20 bit 4 empties the receive queue.
- R11: `irq` is the registered OR of (0x18 bit 0 AND overrun), (bit 3 AND receive-complete) and (bit 4 AND transmit-complete).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq | output | 1 | Combined interrupt request |
| cfg_clock | output | 32 | Clock setup register to the engine |
| cfg_txword | output | 32 | Transmit word setup to the engine |
| cfg_rxword | output | 32 | Receive word setup to the engine |
| cfg_frame | output | 32 | Frame setup to the engine |
| tx_word | output | 32 | Oldest word waiting to be sent |
| tx_valid | output | 1 | A word is offered to the engine |
| tx_ready | input | 1 | The engine takes the offered word |
| rx_word | input | 32 | Word returned by the engine |
| rx_valid | input | 1 | `rx_word` is valid this cycle |

## Verification
The bench fills the transmit queue past its depth with enable low, then turns enable on and drains it. A design that accepted a ninth word, or that offered words while disabled, would hand the engine an extra word or send one too early. The bench overfills the receive queue and expects the ninth word to be lost with only the overrun flag as evidence. A design that overwrote old data would return a wrong word. The bench also clears flags selectively, flushes each queue, and reads an empty queue. These steps catch a design that clears on a zero bit, flushes the wrong queue, or returns stale data, and a threshold flag that fires at the wrong count.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] OFS_CTRL  = 6'h00;
  localparam logic [AW-1:0] OFS_CLOCK = 6'h04;
  localparam logic [AW-1:0] OFS_TXWS  = 6'h08;
  localparam logic [AW-1:0] OFS_RXWS  = 6'h0C;
  localparam logic [AW-1:0] OFS_FRAME = 6'h10;
  localparam logic [AW-1:0] OFS_STAT  = 6'h14;
  localparam logic [AW-1:0] OFS_IMASK = 6'h18;
  localparam logic [AW-1:0] OFS_IFLAG = 6'h1C;
  localparam logic [AW-1:0] OFS_QCTL  = 6'h20;
  localparam logic [AW-1:0] OFS_DATA  = 6'h24;
  // flag positions inside the interrupt status/clear word
  localparam int POS_OVR = 0;
  localparam int POS_RC  = 3;
  localparam int POS_TC  = 4;
  localparam int POS_RDY = 9;
  // queue control fields
  localparam int POS_RXFLUSH = 4;
  localparam int POS_TXFLUSH = 12;
  localparam int POS_TXTH    = 8;
  localparam int POS_RXTH    = 0;
  // compact flag vector order: index 0 overrun, 1 receive complete, 2 transmit complete
  localparam int NFLAG = 3;
endpackage

// File: rtl/spi_front_fifo.sv
module spi_front_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = store[rp];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> full);
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/spi_front_irq.sv
module spi_front_irq
  import spi_front_pkg::*;
#(
  parameter int CW = 4,
  parameter int TW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    rx_count,
  input  logic [TW-1:0]    rx_th,
  input  logic             ovr_evt,
  input  logic             tc_evt,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] flags,
  output logic             ready,
  output logic             irq
);
  logic             ready_q;
  logic [NFLAG-1:0] set_vec;

  assign ready   = (rx_th != '0) && (32'(rx_count) == 32'(rx_th));
  assign set_vec = {tc_evt, ready && !ready_q, ovr_evt};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)                       flags[i] <= 1'b0;
        else if (set_vec[i])           flags[i] <= 1'b1;
        else if (clr_wr && clr_mask[i]) flags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ready_q <= ready;
      irq     <= |(ien & flags);
    end
  end

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !(clr_wr && clr_mask[0])) |=> flags[0]);
  assert_rc_on_match_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |=> flags[1]);
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && ien[0]) |=> irq);
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> !irq);
endmodule

// File: rtl/spi_front.sv
module spi_front
  import spi_front_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic [31:0]   cfg_clock,
  output logic [31:0]   cfg_txword,
  output logic [31:0]   cfg_rxword,
  output logic [31:0]   cfg_frame,
  output logic [31:0]   tx_word,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [31:0]   rx_word,
  input  logic          rx_valid
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          en;
  logic [2:0]    ien;
  logic [TW-1:0] txth, rxth;
  logic          wr_ctrl, wr_data, wr_qctl, wr_iflag, rd_data;
  logic          tx_flush, rx_flush, tx_pop, tx_push;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic [NFLAG-1:0] flags;
  logic          rdy;

  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_qctl  = bus_wr && (bus_addr == OFS_QCTL);
  assign wr_iflag = bus_wr && (bus_addr == OFS_IFLAG);
  assign rd_data  = bus_rd && (bus_addr == OFS_DATA);
  assign tx_flush = wr_qctl && bus_wdata[POS_TXFLUSH];
  assign rx_flush = wr_qctl && bus_wdata[POS_RXFLUSH];
  assign tx_valid = en && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_push  = wr_data && !tx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; ien <= '0; txth <= '0; rxth <= '0;
      cfg_clock <= '0; cfg_txword <= '0; cfg_rxword <= '0; cfg_frame <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:  en <= bus_wdata[0];
        OFS_CLOCK: cfg_clock  <= bus_wdata;
        OFS_TXWS:  cfg_txword <= bus_wdata;
        OFS_RXWS:  cfg_rxword <= bus_wdata;
        OFS_FRAME: cfg_frame  <= bus_wdata;
        OFS_IMASK: ien <= {bus_wdata[POS_TC], bus_wdata[POS_RC], bus_wdata[POS_OVR]};
        OFS_QCTL: begin
          txth <= bus_wdata[POS_TXTH +: TW];
          rxth <= bus_wdata[POS_RXTH +: TW];
        end
        default: ;
      endcase
    end
  end

  spi_front_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(wr_data), .push_data(bus_wdata),
    .pop(tx_pop), .head(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_front_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_valid), .push_data(rx_word),
    .pop(rd_data), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_front_irq #(.CW(CW), .TW(TW)) u_irq (
    .clk(clk), .rst(rst), .rx_count(rx_cnt), .rx_th(rxth),
    .ovr_evt(rx_valid && rx_full),
    .tc_evt(tx_pop && (tx_cnt == CW'(1)) && !tx_push),
    .clr_wr(wr_iflag),
    .clr_mask({bus_wdata[POS_TC], bus_wdata[POS_RC], bus_wdata[POS_OVR]}),
    .ien(ien), .flags(flags), .ready(rdy), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        OFS_CTRL:  bus_rdata[0] <= en;
        OFS_CLOCK: bus_rdata <= cfg_clock;
        OFS_TXWS:  bus_rdata <= cfg_txword;
        OFS_RXWS:  bus_rdata <= cfg_rxword;
        OFS_FRAME: bus_rdata <= cfg_frame;
        OFS_STAT:  bus_rdata[0] <= !rx_empty;
        OFS_IMASK: begin
          bus_rdata[POS_OVR] <= ien[0];
          bus_rdata[POS_RC]  <= ien[1];
          bus_rdata[POS_TC]  <= ien[2];
        end
        OFS_IFLAG: begin
          bus_rdata[POS_OVR] <= flags[0];
          bus_rdata[POS_RC]  <= flags[1];
          bus_rdata[POS_TC]  <= flags[2];
          bus_rdata[POS_RDY] <= rdy;
        end
        OFS_QCTL: begin
          bus_rdata[POS_TXTH +: TW] <= txth;
          bus_rdata[POS_RXTH +: TW] <= rxth;
        end
        OFS_DATA:  bus_rdata <= rx_empty ? '0 : rx_head;
        default: ;
      endcase
    end
  end

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !tx_flush && !wr_ctrl) |=> (tx_valid && $stable(tx_word)));
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_spi_front.sv
`timescale 1ns/1ps
module tb_spi_front;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [31:0] cfg_clock, cfg_txword, cfg_rxword, cfg_frame, tx_word, rx_word = '0;
  int total = 0, failed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_front dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cfg_clock(cfg_clock), .cfg_txword(cfg_txword), .cfg_rxword(cfg_rxword),
    .cfg_frame(cfg_frame), .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid));

  // entry: {is_read, offset, value (write data or expected read)}
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 6'h04, 32'h0000_50FE}, {1'b0, 6'h08, 32'h0000_2060},
    {1'b0, 6'h0C, 32'h0000_0020}, {1'b0, 6'h10, 32'h0000_C000},
    {1'b0, 6'h20, 32'h0000_0305}, {1'b0, 6'h18, 32'hFFFF_FFFF},
    {1'b0, 6'h00, 32'hFFFF_FFFE},
    {1'b1, 6'h04, 32'h0000_50FE}, {1'b1, 6'h08, 32'h0000_2060},
    {1'b1, 6'h0C, 32'h0000_0020}, {1'b1, 6'h10, 32'h0000_C000},
    {1'b1, 6'h20, 32'h0000_0305}, {1'b1, 6'h18, 32'h0000_0019},
    {1'b1, 6'h00, 32'h0000_0000},
    {1'b1, 6'h14, 32'h0000_0000}, {1'b1, 6'h24, 32'h0000_0000},
    {1'b1, 6'h1C, 32'h0000_0000}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_put(input logic [31:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_word = w;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk) rst = 1'b0;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(6'h04, v); chk("R1 clock reg", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) begin
        rd(VEC[i][37:32], v);
        chk(i < 14 ? "R2 readback" : "R5 empty status/read", v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][37:32], VEC[i][31:0]);
      end
    end

    // R3/R4: fill past depth while disabled, then drain
    for (int i = 0; i < 9; i++) wr(6'h24, 32'hA0 + i);
    chk("R4 disabled", {31'b0, tx_valid}, 32'h0);
    wr(6'h00, 32'h1);
    tx_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R3 order", {tx_valid, tx_word[30:0]}, {1'b1, 31'hA0 + 31'(i)});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R3 ninth dropped", {31'b0, tx_valid}, 32'h0);
    idle(2);
    rd(6'h1C, v); chk("R8 tx complete", v, 32'h10);
    chk("R11 irq on tx complete", {31'b0, irq}, 32'h1);
    wr(6'h1C, 32'h19); idle(1);
    rd(6'h1C, v); chk("R9 clear", v, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R4 enable gating, R10 TX flush
    wr(6'h24, 32'h55);
    chk("R4 enabled", {31'b0, tx_valid}, 32'h1);
    wr(6'h00, 32'h0);
    chk("R4 enable cleared", {31'b0, tx_valid}, 32'h0);
    wr(6'h20, 32'h1000);
    wr(6'h00, 32'h1);
    chk("R10 tx flush", {31'b0, tx_valid}, 32'h0);

    // R7 receive threshold
    wr(6'h20, 32'h3); wr(6'h18, 32'h8);
    rx_put(32'h11); rx_put(32'h22); rx_put(32'h33);
    idle(2);
    rd(6'h1C, v); chk("R7 complete+ready", v, 32'h208);
    chk("R11 irq on rc", {31'b0, irq}, 32'h1);
    rd(6'h14, v); chk("R5 not empty", v, 32'h1);
    rd(6'h24, v); chk("R5 word0", v, 32'h11);
    rd(6'h24, v); chk("R5 word1", v, 32'h22);
    rd(6'h24, v); chk("R5 word2", v, 32'h33);
    rd(6'h1C, v); chk("R7 ready drops", v, 32'h8);
    wr(6'h1C, 32'h8); idle(1);
    rd(6'h1C, v); chk("R9 clear rc", v, 32'h0);
    chk("R11 irq low after rc clear", {31'b0, irq}, 32'h0);

    // R6 overrun
    wr(6'h20, 32'h0); wr(6'h18, 32'h1);
    for (int i = 0; i < 9; i++) rx_put(32'h100 + i);
    idle(2);
    rd(6'h1C, v); chk("R6 overrun", v, 32'h1);
    chk("R11 irq on overrun", {31'b0, irq}, 32'h1);
    wr(6'h1C, 32'h18);
    rd(6'h1C, v); chk("R9 zero bit keeps flag", v, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(6'h24, v); chk("R6 kept words", v, 32'h100 + i);
    end
    rd(6'h14, v); chk("R6 ninth discarded", v, 32'h0);
    wr(6'h1C, 32'h1); idle(1);
    rd(6'h1C, v); chk("R9 clear overrun", v, 32'h0);
    chk("R11 irq low after overrun clear", {31'b0, irq}, 32'h0);

    // R10 RX flush
    rx_put(32'h77); rx_put(32'h78);
    wr(6'h20, 32'h10);
    rd(6'h14, v); chk("R10 rx flush status", v, 32'h0);
    rd(6'h24, v); chk("R10 rx flush data", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule